// File: doc/BRIEF.md
# Interleaved Pixel Component Packer

The packer sits at the end of an image pipeline's output path. It takes one pixel per handshake as three colour components (luma plus two chroma, or three RGB channels carried on the same lanes). It turns them into 32-bit words ready for a memory writer. A frame-start marker on the first pixel of a frame captures the format controls. The controls are:

- the word format: 8-bit components with a padding byte, or 10-bit components;
- the slot that luma takes among the three components;
- which chroma component leads;
- the programmable padding value;
- for 10-bit data, whether each pixel fills its own word or pixels are packed back to back.

In the back-to-back mode, a 30-bit pixel does not fill a 32-bit word, so pixels straddle word boundaries. A frame-end marker on the last pixel then forces out any partly filled word. Both sides use valid/ready handshakes. A stalled output holds the input back rather than losing data.

Top module: `comp_packer`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. Until a pixel marked with `in_sof` is accepted, the block uses 8-bit format, luma first, U before V and padding value 0.
- R2: In 8-bit format (`cfg_wide`=0) each pixel gives one word. Bits [7:0] of ordered components 0, 1 and 2 go to word bits [7:0], [15:8] and [23:16]. `cfg_pad[7:0]` goes to bits [31:24].
- R3: `cfg_ypos` sets the component order. 00 gives luma, C1, C2. 01 gives C1, luma, C2. 10 gives C1, C2, luma. 11 behaves like 00.
- R4: `cfg_vfirst`=0 makes C1 the U input and C2 the V input. `cfg_vfirst`=1 swaps them.
- R5: In aligned 10-bit format (`cfg_wide`=1, `cfg_align`=1) each pixel gives one word. Components 0, 1 and 2 go to bits [9:0], [19:10] and [29:20]. `cfg_pad[1:0]` goes to bits [31:30].
- R6: In packed 10-bit format (`cfg_wide`=1, `cfg_align`=0) each pixel forms a 30-bit unit {c2,c1,c0}. Units are appended to a bit stream starting at stream bit 0. Stream bits [32k+31:32k] leave as word k as soon as they are all present.
- R7: Accepting a pixel with `in_eof` high flushes the stream. Any leftover bits leave as one more word with the unused upper bits zero. No extra word appears when the frame ends on a word boundary.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. `in_ready` drops once a full word waits behind the stalled output. Words leave in order with none lost or repeated.
- R9: The format controls are captured only on an accepted pixel with `in_sof` high, and apply to that pixel onward. Control changes later in the frame have no effect.
- R10: In 8-bit and aligned formats with `out_ready` held high, `in_ready` stays high. One pixel is taken on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pad | input | 8 | Padding value |
| cfg_ypos | input | 2 | Luma slot code |
| cfg_vfirst | input | 1 | 1: V leads U |
| cfg_wide | input | 1 | 1: 10-bit components |
| cfg_align | input | 1 | 1: one 10-bit pixel per word |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_sof | input | 1 | First pixel of frame, captures controls |
| in_eof | input | 1 | Last pixel of frame, flushes stream |
| in_y | input | 10 | Luma (or first RGB channel) |
| in_u | input | 10 | U chroma |
| in_v | input | 10 | V chroma |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Packed word |

## Verification
The reserved luma code is probed directly: a decoder that treats 11 as a real slot would produce a scrambled word instead of the luma-first layout. A packed frame of sixteen pixels, run while the consumer drops ready every third cycle, catches two faults. A wrong carry of leftover bits corrupts every later word. A flush that fires on a word boundary adds a sixteenth word. A short three-pixel frame checks that the tail word is zero-filled, not left with stale bits. The remaining tests each target one fault:

- A long stall is held against the output register and `in_ready`. A block that overwrites a held word changes `out_data` during the stall.
- A mid-frame control change is applied to the second pixel of a frame. A block that samples controls on every pixel changes that pixel's format.
- A second reset is applied after non-default formats have been used. A block that leaves the captured format uncleared gives the old format to a frame that has no start marker.

// File: rtl/cpk_pkg.sv
`timescale 1ns/1ps
package cpk_pkg;

    localparam int COMP_W   = 10;
    localparam int NARROW_W = 8;
    localparam int PAD_W    = 8;
    localparam int WORD_W   = 32;
    localparam int SLOTS    = 3;
    localparam int PIX_BITS = SLOTS * COMP_W;
    localparam int TAIL_W   = WORD_W - PIX_BITS;
    localparam int ACC_W    = 2 * WORD_W;
    localparam int FILL_W   = $clog2(ACC_W);
    localparam int WIDX_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        YPOS_FIRST = 2'b00,
        YPOS_MID   = 2'b01,
        YPOS_LAST  = 2'b10,
        YPOS_RSVD  = 2'b11
    } ypos_e;

    typedef struct packed {
        logic [PAD_W-1:0] pad;
        ypos_e            ypos;
        logic             v_first;
        logic             wide;
        logic             align;
    } fmt_t;

    typedef struct packed {
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] u;
        logic [COMP_W-1:0] v;
    } pix_t;

    localparam fmt_t FMT_RESET = '{pad: '0, ypos: YPOS_FIRST,
                                   v_first: 1'b0, wide: 1'b0, align: 1'b0};

    // slot index taken by luma for a given code; reserved code maps to slot 0
    function automatic logic [1:0] luma_slot(ypos_e code);
        case (code)
            YPOS_MID:  return 2'd1;
            YPOS_LAST: return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/cpk_fmt_hold.sv
`timescale 1ns/1ps
module cpk_fmt_hold
    import cpk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic sof,
    input  fmt_t fmt_in,
    output fmt_t fmt_use
);
    fmt_t fmt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= FMT_RESET;
        end else if (take && sof) begin
            fmt_q <= fmt_in;
        end
    end

    // a frame-start pixel already uses the controls it brings
    assign fmt_use = sof ? fmt_in : fmt_q;
endmodule

// File: rtl/cpk_order.sv
`timescale 1ns/1ps
module cpk_order
    import cpk_pkg::*;
(
    input  pix_t              pix,
    input  fmt_t              fmt,
    output logic [WORD_W-1:0] unit,
    output logic [FILL_W-1:0] unit_len
);
    logic [1:0]                 y_slot;
    logic [1:0]                 lead_slot;
    logic [COMP_W-1:0]          c_lead;
    logic [COMP_W-1:0]          c_trail;
    logic [COMP_W-1:0]          slot_val [SLOTS];
    logic [SLOTS*NARROW_W-1:0]  narrow_body;
    logic [SLOTS*COMP_W-1:0]    wide_body;

    always_comb begin
        y_slot    = luma_slot(fmt.ypos);
        lead_slot = (y_slot == 2'd0) ? 2'd1 : 2'd0;
        c_lead    = fmt.v_first ? pix.v : pix.u;
        c_trail   = fmt.v_first ? pix.u : pix.v;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign slot_val[k] = (y_slot == 2'(k))    ? pix.y  :
                             (lead_slot == 2'(k)) ? c_lead : c_trail;
        assign narrow_body[k*NARROW_W +: NARROW_W] = slot_val[k][NARROW_W-1:0];
        assign wide_body[k*COMP_W +: COMP_W]       = slot_val[k];
    end

    always_comb begin
        if (!fmt.wide) begin
            unit     = {fmt.pad, narrow_body};
            unit_len = FILL_W'(WORD_W);
        end else if (fmt.align) begin
            unit     = {fmt.pad[TAIL_W-1:0], wide_body};
            unit_len = FILL_W'(WORD_W);
        end else begin
            unit     = {{TAIL_W{1'b0}}, wide_body};
            unit_len = FILL_W'(PIX_BITS);
        end
    end
endmodule

// File: rtl/cpk_accum.sv
`timescale 1ns/1ps
module cpk_accum
    import cpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_eof,
    input  logic [WORD_W-1:0] unit,
    input  logic [FILL_W-1:0] unit_len,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [FILL_W-1:0] fill
);
    logic [ACC_W-1:0]  acc_q, acc_n, rem_acc;
    logic [FILL_W-1:0] fill_q, fill_n, rem_fill;
    logic              flush_q, flush_n;
    logic              ov_q;
    logic [WORD_W-1:0] od_q;
    logic              can_load, full, emit, take;

    assign can_load = !ov_q || out_ready;
    assign full     = fill_q >= FILL_W'(WORD_W);
    assign emit     = can_load && (full || flush_q);
    assign in_ready = !flush_q && (!full || emit);
    assign take     = in_valid && in_ready;

    always_comb begin
        rem_acc  = acc_q;
        rem_fill = fill_q;
        if (emit) begin
            if (full) begin
                rem_acc  = acc_q >> WORD_W;
                rem_fill = fill_q - FILL_W'(WORD_W);
            end else begin
                rem_acc  = '0;
                rem_fill = '0;
            end
        end
        acc_n   = rem_acc;
        fill_n  = rem_fill;
        flush_n = flush_q;
        if (emit && !full) begin
            flush_n = 1'b0;
        end
        if (take) begin
            acc_n  = rem_acc | (ACC_W'(unit) << rem_fill);
            fill_n = rem_fill + unit_len;
            if (in_eof) begin
                flush_n = (fill_n[WIDX_W-1:0] != '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            fill_q  <= '0;
            flush_q <= 1'b0;
            ov_q    <= 1'b0;
            od_q    <= '0;
        end else begin
            acc_q   <= acc_n;
            fill_q  <= fill_n;
            flush_q <= flush_n;
            if (emit) begin
                ov_q <= 1'b1;
                od_q <= acc_q[WORD_W-1:0];
            end else if (out_ready) begin
                ov_q <= 1'b0;
            end
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign fill      = fill_q;
endmodule

// File: rtl/comp_packer.sv
`timescale 1ns/1ps
module comp_packer
    import cpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cfg_pad,
    input  logic [1:0]  cfg_ypos,
    input  logic        cfg_vfirst,
    input  logic        cfg_wide,
    input  logic        cfg_align,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [9:0]  in_y,
    input  logic [9:0]  in_u,
    input  logic [9:0]  in_v,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);
    fmt_t              fmt_in, fmt_use;
    pix_t              pix;
    logic [WORD_W-1:0] unit;
    logic [FILL_W-1:0] unit_len;
    logic [FILL_W-1:0] fill_lvl;

    assign fmt_in = '{pad: cfg_pad, ypos: ypos_e'(cfg_ypos),
                      v_first: cfg_vfirst, wide: cfg_wide, align: cfg_align};
    assign pix    = '{y: in_y, u: in_u, v: in_v};

    cpk_fmt_hold i_fmt (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid && in_ready),
        .sof     (in_sof),
        .fmt_in  (fmt_in),
        .fmt_use (fmt_use)
    );

    cpk_order i_order (
        .pix      (pix),
        .fmt      (fmt_use),
        .unit     (unit),
        .unit_len (unit_len)
    );

    cpk_accum i_accum (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_eof    (in_eof),
        .unit      (unit),
        .unit_len  (unit_len),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .fill      (fill_lvl)
    );
endmodule

// File: rtl/cpk_checker.sv
`timescale 1ns/1ps
module cpk_checker
    import cpk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [FILL_W-1:0] fill
);
    // R1: output idle on the first cycle after reset
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R8: a stalled word holds its value
    p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: input taken under a stall only while the stream has room
    p_room_under_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && out_valid && !out_ready) |-> (fill < FILL_W'(WORD_W)));

    // R6: a complete word moves to the output as soon as it can
    p_full_word_leaves_r6: assert property (@(posedge clk) disable iff (rst)
        ((fill >= FILL_W'(WORD_W)) && (!out_valid || out_ready)) |=> out_valid);

    // R2: a presented word carries known bits
    p_known_word_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_data));
endmodule

bind comp_packer cpk_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .fill      (fill_lvl)
);

// File: tb/test_comp_packer.sv
`timescale 1ns/1ps
module test_comp_packer;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [7:0]  cfg_pad = 8'h00;
    logic [1:0]  cfg_ypos = 2'b00;
    logic        cfg_vfirst = 1'b0, cfg_wide = 1'b0, cfg_align = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [9:0]  in_y = '0, in_u = '0, in_v = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    comp_packer i_comp_packer (
        .clk(clk), .rst(rst), .cfg_pad(cfg_pad), .cfg_ypos(cfg_ypos),
        .cfg_vfirst(cfg_vfirst), .cfg_wide(cfg_wide), .cfg_align(cfg_align),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof),
        .in_y(in_y), .in_u(in_u), .in_v(in_v),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    localparam logic [9:0] PY = 10'h3C1, PU = 10'h242, PV = 10'h183;

    // {wide, align, ypos, vfirst, pad, expected word}
    localparam logic [44:0] VEC [9] = '{
        {1'b0, 1'b0, 2'b00, 1'b0, 8'h5A, 32'h5A8342C1},
        {1'b0, 1'b0, 2'b01, 1'b0, 8'h5A, 32'h5A83C142},
        {1'b0, 1'b0, 2'b10, 1'b0, 8'h5A, 32'h5AC18342},
        {1'b0, 1'b0, 2'b11, 1'b0, 8'h5A, 32'h5A8342C1},
        {1'b0, 1'b0, 2'b00, 1'b1, 8'h5A, 32'h5A4283C1},
        {1'b0, 1'b0, 2'b10, 1'b1, 8'h5A, 32'h5AC14283},
        {1'b1, 1'b1, 2'b00, 1'b0, 8'h5A, 32'h98390BC1},
        {1'b1, 1'b1, 2'b01, 1'b1, 8'h5A, 32'hA42F0583},
        {1'b1, 1'b1, 2'b10, 1'b0, 8'h03, 32'hFC160E42}
    };

    int n_chk = 0, n_bad = 0;
    logic [31:0] got [256];
    int n_got = 0;
    logic hold_low = 1'b0, jitter = 1'b0;
    int cyc = 0;
    logic stall_done = 1'b0;
    int w_st = 0;

    always @(negedge clk) begin
        cyc++;
        out_ready = hold_low ? 1'b0 : (jitter ? ((cyc % 3) != 0) : 1'b1);
    end

    always @(negedge clk) begin
        #2;
        if (out_valid && out_ready && !rst) begin
            if (n_got < 256) got[n_got] = out_data;
            n_got++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic set_cfg(logic wide, logic align, logic [1:0] yp, logic vf, logic [7:0] pad);
        @(negedge clk);
        cfg_wide = wide; cfg_align = align; cfg_ypos = yp; cfg_vfirst = vf; cfg_pad = pad;
    endtask

    task automatic send(logic [9:0] y, logic [9:0] u, logic [9:0] v,
                        logic sof, logic eof, output int waits);
        logic done;
        waits = 0;
        done = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_y = y; in_u = u; in_v = v; in_sof = sof; in_eof = eof;
        while (!done) begin
            #1;
            if (in_ready) done = 1'b1;
            else begin
                waits++;
                @(negedge clk);
            end
        end
        @(posedge clk);
        #1 in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic wait_words(int target);
        while (n_got < target) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // independent model: {c2,c1,c0} from the ordering rules
    function automatic logic [29:0] body(logic [9:0] y, logic [9:0] u, logic [9:0] v,
                                         logic [1:0] yp, logic vf);
        logic [9:0] a, b;
        a = vf ? v : u;
        b = vf ? u : v;
        case (yp)
            2'b01:   return {b, y, a};
            2'b10:   return {y, b, a};
            default: return {b, a, y};
        endcase
    endfunction

    function automatic logic [31:0] word8(logic [29:0] bd, logic [7:0] pad);
        return {pad, bd[27:20], bd[17:10], bd[7:0]};
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        int base, w, wsum;
        logic [511:0] strm;
        logic [9:0] py [16], pu [16], pv [16];

        // ---------- R1: reset state and default format ----------
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
        set_cfg(1'b1, 1'b0, 2'b10, 1'b1, 8'hFF);
        base = n_got;
        send(PY, PU, PV, 1'b0, 1'b1, w);
        wait_words(base + 1);
        check("R1 default format before first sof", got[base], 32'h008342C1);

        // ---------- vector table: R2 R3 R4 R5 ----------
        for (int i = 0; i < 9; i++) begin
            string tag;
            set_cfg(VEC[i][44], VEC[i][43], VEC[i][42:41], VEC[i][40], VEC[i][39:32]);
            tag = VEC[i][44] ? "R5 aligned word" :
                  (VEC[i][40] ? "R4 chroma order" :
                  (VEC[i][42:41] != 2'b00 ? "R3 luma slot" : "R2 8-bit layout"));
            base = n_got;
            send(PY, PU, PV, 1'b1, 1'b1, w);
            wait_words(base + 1);
            check(tag, got[base], VEC[i][31:0]);
        end

        // ---------- R10: full rate in 8-bit format ----------
        set_cfg(1'b0, 1'b0, 2'b00, 1'b0, 8'h5A);
        base = n_got;
        wsum = 0;
        for (int k = 0; k < 4; k++) begin
            send(PY + 10'(k), PU + 10'(3 * k), PV + 10'(5 * k), k == 0, k == 3, w);
            wsum += w;
        end
        wait_words(base + 4);
        check("R10 wait cycles in 4-pixel burst", 32'(wsum), 32'd0);
        for (int k = 0; k < 4; k++)
            check("R10 burst word", got[base + k],
                  word8(body(PY + 10'(k), PU + 10'(3 * k), PV + 10'(5 * k), 2'b00, 1'b0), 8'h5A));

        // ---------- R6: packed 10-bit frame under output jitter ----------
        set_cfg(1'b1, 1'b0, 2'b01, 1'b1, 8'hEE);
        jitter = 1'b1;
        strm = '0;
        for (int i = 0; i < 16; i++) begin
            py[i] = 10'((i * 73 + 17) & 10'h3FF);
            pu[i] = 10'((i * 151 + 300) & 10'h3FF);
            pv[i] = 10'((i * 29 + 900) & 10'h3FF);
            strm[i * 30 +: 30] = body(py[i], pu[i], pv[i], 2'b01, 1'b1);
        end
        base = n_got;
        for (int i = 0; i < 16; i++)
            send(py[i], pu[i], pv[i], i == 0, i == 15, w);
        wait_words(base + 15);
        jitter = 1'b0;
        check("R7 word count on boundary-ending frame", 32'(n_got - base), 32'd15);
        for (int k = 0; k < 15; k++)
            check("R6 packed word", got[base + k], strm[k * 32 +: 32]);

        // ---------- R7: flush of a short packed frame ----------
        set_cfg(1'b1, 1'b0, 2'b00, 1'b0, 8'hFF);
        strm = '0;
        for (int i = 0; i < 3; i++)
            strm[i * 30 +: 30] = body(py[i], pu[i], pv[i], 2'b00, 1'b0);
        base = n_got;
        for (int i = 0; i < 3; i++)
            send(py[i], pu[i], pv[i], i == 0, i == 2, w);
        wait_words(base + 3);
        check("R7 word count after flush", 32'(n_got - base), 32'd3);
        for (int k = 0; k < 3; k++)
            check("R7 flushed word", got[base + k], strm[k * 32 +: 32]);

        // ---------- R8: long output stall ----------
        set_cfg(1'b0, 1'b0, 2'b00, 1'b0, 8'h77);
        hold_low = 1'b1;
        base = n_got;
        stall_done = 1'b0;
        fork
            begin
                send(10'h011, 10'h022, 10'h033, 1'b1, 1'b0, w_st);
                send(10'h044, 10'h055, 10'h066, 1'b0, 1'b0, w_st);
                send(10'h077, 10'h088, 10'h099, 1'b0, 1'b1, w_st);
                stall_done = 1'b1;
            end
        join_none
        repeat (8) @(negedge clk);
        #1;
        check("R8 out_valid held during stall", {31'd0, out_valid}, 32'd1);
        check("R8 out_data held during stall", out_data, 32'h77332211);
        check("R8 in_ready low behind stalled word", {31'd0, in_ready}, 32'd0);
        hold_low = 1'b0;
        wait (stall_done);
        wait_words(base + 3);
        check("R8 word count after stall", 32'(n_got - base), 32'd3);
        check("R8 word 0 order", got[base],     32'h77332211);
        check("R8 word 1 order", got[base + 1], 32'h77665544);
        check("R8 word 2 order", got[base + 2], 32'h77998877);

        // ---------- R9: controls change inside a frame ----------
        set_cfg(1'b0, 1'b0, 2'b00, 1'b0, 8'h11);
        base = n_got;
        send(PY, PU, PV, 1'b1, 1'b0, w);
        set_cfg(1'b1, 1'b1, 2'b10, 1'b1, 8'hFF);
        send(PU, PV, PY, 1'b0, 1'b1, w);
        wait_words(base + 2);
        check("R9 first pixel of frame", got[base], 32'h118342C1);
        check("R9 mid-frame control change ignored", got[base + 1],
              word8(body(PU, PV, PY, 2'b00, 1'b0), 8'h11));

        // ---------- R1: second reset clears captured format ----------
        set_cfg(1'b1, 1'b1, 2'b01, 1'b1, 8'hFF);
        base = n_got;
        send(PY, PU, PV, 1'b1, 1'b1, w);
        wait_words(base + 1);
        do_reset();
        @(negedge clk); #1;
        check("R1 out_valid after second reset", {31'd0, out_valid}, 32'd0);
        base = n_got;
        send(PY, PU, PV, 1'b0, 1'b1, w);
        wait_words(base + 1);
        check("R1 format cleared by reset", got[base], 32'h008342C1);

        summary();
    end
endmodule